// File: doc/BRIEF.md
# Timed Store Buffer Occupancy Tracker

This block models how long a core must wait on its posted stores. It holds an ordered queue of outstanding stores. Each entry carries only the number of memory cycles that store still needs. The data and the write-back are handled elsewhere. Only the oldest entry makes progress: its count drops by one each cycle, and the entry leaves the queue on the cycle its last remaining cycle is spent. The next entry then becomes the oldest and starts counting on the following cycle. A queue whose entries were pushed with costs c1..cn therefore drains in exactly c1+...+cn cycles.

The core presents a store strobe with a cycle cost, or a load strobe, and holds it until `stall` is low. A store is held back while the queue is at the capacity set on `cap_len`, unless the oldest entry retires in that same cycle. A load is held back until every buffered store has left. Each cycle in which `stall` is high adds one to a wait-cycle counter. Maximum depth, cost width and counter width are parameters.

Top module: `sbt_store_tracker`

## Requirements
- R1: After reset the occupancy and the wait counter read zero, and `stall` is low while no request is presented.
- R2: A store accepted with a nonzero cost raises the occupancy by one at the next clock edge, unless an entry retires at that edge. A store accepted with cost 0 is taken at once and never occupies an entry.
- R3: Only the oldest entry counts down, by one per cycle. An entry of cost c that is oldest from the cycle after it was pushed leaves the queue c edges after its push.
- R4: Entries retire strictly in push order. After stores of cost 2 and then 5 on back-to-back cycles into an empty queue, the occupancy is 2, then 1 from the third edge, and 0 from the eighth edge.
- R5: A store stalls while the occupancy, less one if the oldest entry retires this cycle, is at least `cap_len`.
- R6: A store accepted in the cycle in which the oldest entry retires leaves the occupancy unchanged.
- R7: A load stalls while the occupancy is nonzero and is accepted only when the queue is empty.
- R8: The wait counter rises by exactly one at each edge where `stall` was high and holds otherwise.
- R9: `cap_len` must lie in 1..DEPTH and may change at any time. Lowering it below the current occupancy blocks stores until enough entries have retired.
- R10: A request is taken only in a cycle where `stall` is low. When a store and a load are presented together, both are held while either one is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_len | input | CW | Configured capacity, 1..DEPTH |
| st_req | input | 1 | Store request, held until accepted |
| st_cost | input | COST_W | Memory cycles the store needs |
| ld_req | input | 1 | Load request, held until accepted |
| stall | output | 1 | Request present and must wait this cycle |
| occ | output | CW | Current number of buffered stores |
| wait_cnt | output | WAIT_W | Accumulated stall cycles |

## Verification
Back-to-back stores of different costs into an empty queue show FIFO order and that only the oldest entry counts down. Zero-cost stores separate the "taken but not buffered" case from a normal push. A full queue that is offered a store separates a stall on a busy oldest entry from acceptance on the retiring cycle, where the occupancy must stay flat. Loads, paired strobes and a lowered capacity check drain-before-load and blocking below the occupancy. Long random mixes with shifting capacity then compare stall, occupancy and the wait count every cycle against a queue model in the bench.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
   // Circular increment of a ring index for a ring of 'depth' slots.
   function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
      return (idx + 1 >= depth) ? 0 : idx + 1;
   endfunction
endpackage

// File: rtl/sbt_entry_bank.sv
module sbt_entry_bank #(
   parameter int DEPTH  = 8,
   parameter int COST_W = 6,
   parameter int AW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_idx,
   input  logic [COST_W-1:0] wr_cost,
   input  logic              dec_en,
   input  logic [AW-1:0]     old_idx,
   output logic [COST_W-1:0] old_cost
);
   logic [COST_W-1:0] cnt_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      localparam logic [AW-1:0] IDX = AW'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q[g] <= '0;
         else if (wr_en && wr_idx == IDX)
            cnt_q[g] <= wr_cost;
         else if (dec_en && old_idx == IDX)
            cnt_q[g] <= cnt_q[g] - 1'b1;
      end
   end

   assign old_cost = cnt_q[old_idx];

   AST_NO_ZERO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_cost != '0); // R2
   AST_OLDEST_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_en |-> old_cost != '0); // R3
endmodule

// File: rtl/sbt_ring_ctrl.sv
module sbt_ring_ctrl
   import sbt_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 3,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] head,
   output logic [AW-1:0] tail,
   output logic [CW-1:0] occ
);
   logic [AW-1:0] head_q, tail_q;
   logic [CW-1:0] occ_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
      end else begin
         if (push) head_q <= AW'(ring_next(32'(head_q), DEPTH));
         if (pop)  tail_q <= AW'(ring_next(32'(tail_q), DEPTH));
         unique case ({push, pop})
            2'b10:   occ_q <= occ_q + 1'b1;
            2'b01:   occ_q <= occ_q - 1'b1;
            default: occ_q <= occ_q;
         endcase
      end
   end

   assign head = head_q;
   assign tail = tail_q;
   assign occ  = occ_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> occ_q < CW'(DEPTH)); // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> occ_q != '0); // R3
   AST_EMPTY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q == '0 |-> head_q == tail_q); // R4
endmodule

// File: rtl/sbt_wait_acc.sv
module sbt_wait_acc #(
   parameter int WAIT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   output logic [WAIT_W-1:0] cnt
);
   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/sbt_store_tracker.sv
module sbt_store_tracker #(
   parameter int DEPTH  = 8,
   parameter int COST_W = 6,
   parameter int WAIT_W = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     cap_len,
   input  logic              st_req,
   input  logic [COST_W-1:0] st_cost,
   input  logic              ld_req,
   output logic              stall,
   output logic [CW-1:0]     occ,
   output logic [WAIT_W-1:0] wait_cnt
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("sbt_store_tracker: DEPTH must be at least 2");
   end
   if (COST_W < 1 || WAIT_W < 2) begin : g_bad_width
      $error("sbt_store_tracker: COST_W >= 1 and WAIT_W >= 2 required");
   end

   logic [AW-1:0]     head, tail;
   logic [COST_W-1:0] old_cost;
   logic              counting, retire, push, st_block, ld_block;
   logic [CW-1:0]     occ_after;

   // The oldest entry counts down whenever the queue holds anything.
   assign counting  = occ != '0;
   assign retire    = counting && old_cost == COST_W'(1);
   assign occ_after = occ - CW'(retire);
   assign st_block  = occ_after >= cap_len;
   assign ld_block  = counting;
   assign stall     = (st_req && st_block) || (ld_req && ld_block);
   assign push      = st_req && !stall && st_cost != '0;

   sbt_entry_bank #(.DEPTH(DEPTH), .COST_W(COST_W), .AW(AW)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (push),
      .wr_idx   (head),
      .wr_cost  (st_cost),
      .dec_en   (counting),
      .old_idx  (tail),
      .old_cost (old_cost)
   );

   sbt_ring_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) i_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (retire),
      .head  (head),
      .tail  (tail),
      .occ   (occ)
   );

   sbt_wait_acc #(.WAIT_W(WAIT_W)) i_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (stall),
      .cnt   (wait_cnt)
   );

   AST_CAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_len != '0) && (cap_len <= CW'(DEPTH))); // R9
   AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req && !stall) |-> occ == '0); // R7
   AST_SWAP_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (push && retire) |=> $stable(occ)); // R6
   AST_WAIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> wait_cnt == $past(wait_cnt) + 1'b1); // R8
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> $stable(wait_cnt)); // R8
   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !retire) |=> occ == $past(occ) + 1'b1); // R2
endmodule

// File: tb/test_sbt_store_tracker.sv
module test_sbt_store_tracker;
   localparam int PERIOD = 10;
   localparam int DEPTH  = 8;
   localparam int COST_W = 6;
   localparam int WAIT_W = 16;
   localparam int CW     = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CW-1:0]     cap_len = CW'(DEPTH);
   logic              st_req = 1'b0;
   logic [COST_W-1:0] st_cost = '0;
   logic              ld_req = 1'b0;
   logic              stall;
   logic [CW-1:0]     occ;
   logic [WAIT_W-1:0] wait_cnt;

   int total = 0;
   int bad   = 0;
   int mq[$];
   int m_wait = 0;
   bit last_stall = 0;

   always #(PERIOD/2) clk = ~clk;

   sbt_store_tracker #(.DEPTH(DEPTH), .COST_W(COST_W), .WAIT_W(WAIT_W)) i_sbt_store_tracker (
      .clk(clk), .rst_n(rst_n), .cap_len(cap_len), .st_req(st_req), .st_cost(st_cost),
      .ld_req(ld_req), .stall(stall), .occ(occ), .wait_cnt(wait_cnt)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit model_stall(input bit st, input bit ld);
      int rm = (mq.size() > 0 && mq[0] == 1) ? 1 : 0;
      return (st && (mq.size() - rm >= int'(cap_len))) || (ld && mq.size() != 0);
   endfunction

   // One cycle: drive, check stall, clock, advance model, check state.
   task automatic step(input bit st, input int cost, input bit ld);
      bit sm;
      string tag;
      @(negedge clk);
      st_req = st; st_cost = COST_W'(cost); ld_req = ld;
      #1;
      sm  = model_stall(st, ld);
      tag = ld ? (st ? "R10" : "R7") : (st ? "R5" : "R10");
      check(tag, int'(stall), int'(sm));
      last_stall = stall;
      @(posedge clk);
      if (mq.size() > 0) begin
         if (mq[0] == 1) void'(mq.pop_front());
         else mq[0] = mq[0] - 1;
      end
      if (st && !sm && cost != 0) mq.push_back(cost);
      if (sm) m_wait++;
      #1;
      check("R3", int'(occ), mq.size());
      check("R8", int'(wait_cnt), m_wait);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0);
   endtask

   initial begin
      #(PERIOD * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      #1;
      check("R1", int'(occ), 0);
      check("R1", int'(wait_cnt), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R1", int'(stall), 0);

      // R2: zero-cost store never occupies
      step(1, 0, 0);
      check("R2", int'(occ), 0);
      step(1, 3, 0);
      check("R2", int'(occ), 1);
      idle(2);
      check("R3", int'(occ), 1);
      idle(1);
      check("R3", int'(occ), 0);

      // R4: costs 2 then 5, back to back
      step(1, 2, 0);
      step(1, 5, 0);
      check("R4", int'(occ), 2);
      idle(1);
      check("R4", int'(occ), 1);
      idle(4);
      check("R4", int'(occ), 1);
      idle(1);
      check("R4", int'(occ), 0);

      // R5 / R6: full queue accepts only on the retiring cycle
      cap_len = CW'(2);
      step(1, 3, 0);
      step(1, 3, 0);
      step(1, 4, 0);
      check("R5", int'(last_stall), 1);
      for (int i = 0; i < 10 && last_stall; i++) step(1, 4, 0);
      check("R6", int'(last_stall), 0);
      check("R6", int'(occ), 2);

      // R10: paired strobes held while load is blocked
      step(1, 1, 1);
      check("R10", int'(last_stall), 1);
      check("R10", int'(occ), 2);

      // R7: load waits for complete drain
      for (int i = 0; i < 20; i++) begin
         step(0, 0, 1);
         if (!last_stall) break;
      end
      check("R7", int'(occ), 0);

      // R9: lowering capacity below occupancy blocks stores
      cap_len = CW'(4);
      for (int i = 0; i < 4; i++) step(1, 20, 0);
      check("R9", int'(occ), 4);
      cap_len = CW'(2);
      step(1, 1, 0);
      check("R9", int'(last_stall), 1);
      idle(90);
      check("R9", int'(occ), 0);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 50) == 0) cap_len = CW'(1 + ($urandom % DEPTH));
         step(($urandom % 2) == 1, int'($urandom % 7), ($urandom % 10) == 0);
      end
      idle(60);
      check("R3", int'(occ), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule